// File: doc/BRIEF.md
# System Control Register Block

This block holds the system control registers of a processor's control coprocessor and decodes the register-transfer instructions that reach it. Each transfer is one 32-bit instruction word, a direction flag and, for writes, the value taken from a core register. A write updates one of these registers: identification, cache type, control, translation base, domain access, fault status or fault address. A write can also request a maintenance operation. A read returns a register value together with the index of the core register that is to receive it.

Maintenance writes do not store anything. Instead they raise single-cycle pulses toward the cache, which is invalidated as a whole, and toward the TLB, which is invalidated either as a whole or one entry at a time using the written value as the address. The MMU's fault path can load the fault status and fault address registers directly. The low bits of the control register are exported as enables for translation, alignment checking and the cache.

Top module: `sysctl_cp_regs`

## Requirements
- R1: The instruction fields are: major opcode at bits [23:21], primary register at [19:16], core register at [15:12], minor opcode at [7:5] and secondary register at [3:0]. A write whose major opcode is nonzero, or whose core register is 15, changes no register, raises no pulse and raises no undefined flag.
- R2: A read whose major opcode is nonzero, whose core register is 15, or whose secondary register is nonzero produces no response and no undefined flag.
- R3: Primary registers 1, 2, 3, 5 and 6 select control, translation base, domain access, fault status and fault address. A write updates the register at the next edge. A read raises `rd_valid_o` for one cycle after the edge, with the register value and the core register index.
- R4: Primary register 0 with minor opcode 0 selects the ID register, and with minor opcode 1 selects the cache type register. Both are readable and writable. After reset they hold `ID_RESET` and `CTYPE_RESET`.
- R5: After reset the control register reads 0x00000070, translation base, domain, fault status and fault address read zero, and all pulses are low.
- R6: A write to primary register 7 with minor opcode 0 raises `cache_inv_all_o` for exactly one cycle after the edge. Other minor opcodes on register 7 do nothing.
- R7: A write to primary register 8 raises `tlb_inv_all_o` for one cycle when the minor opcode is 0. It raises `tlb_inv_entry_o` for one cycle, with `tlb_inv_addr_o` equal to the written value, when the minor opcode is 1.
- R8: A read of primary register 7 or 8 returns a valid response with data zero.
- R9: An accepted transfer to primary register 4 or 9 to 15, or to register 0 with a minor opcode above 1, raises `undef_o` for one cycle and changes no state.
- R10: When `fault_valid_i` is high, fault status and fault address take `fault_status_i` and `fault_addr_i` at that edge. This overrides a write to either register in the same cycle.
- R11: `mmu_en_o`, `align_chk_en_o` and `cache_en_o` follow control bits 0, 1 and 2.
- R12: A write ignores the secondary register field: a nonzero value still updates the selected register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| xfer_valid_i | input | 1 | Transfer instruction present this cycle |
| xfer_write_i | input | 1 | 1 = write to block, 0 = read from block |
| instr_i | input | 32 | Transfer instruction word |
| core_wdata_i | input | 32 | Core register value for writes |
| rd_valid_o | output | 1 | Read response valid |
| rd_dest_o | output | 4 | Core register to receive the read data |
| rd_data_o | output | 32 | Read data |
| undef_o | output | 1 | Unsupported register accessed |
| fault_valid_i | input | 1 | MMU fault load strobe |
| fault_status_i | input | 32 | Fault status to load |
| fault_addr_i | input | 32 | Fault address to load |
| cache_inv_all_o | output | 1 | Invalidate whole cache pulse |
| tlb_inv_all_o | output | 1 | Invalidate whole TLB pulse |
| tlb_inv_entry_o | output | 1 | Invalidate one TLB entry pulse |
| tlb_inv_addr_o | output | 32 | Address for single-entry invalidate |
| mmu_en_o | output | 1 | Translation enable |
| align_chk_en_o | output | 1 | Alignment check enable |
| cache_en_o | output | 1 | Cache enable |

## Verification
The assertions check the following on every cycle:
- At most one maintenance pulse is high at a time.
- A single-entry pulse carries the value written with it.
- A fault strobe lands in both fault registers.
- A read with a nonzero secondary field never yields a response.
- An ignored or undefined access leaves the control register unchanged.

Only the directed scenarios can show the following:
- The full register map and the reset values.
- The zero read of the maintenance registers.
- That writes ignore the secondary field.
- The override of a same-cycle write by a fault.

// File: rtl/sysctl_cp_pkg.sv
package sysctl_cp_pkg;
  localparam int unsigned XLEN       = 32;
  localparam int unsigned IDX_W      = 4;
  localparam int unsigned OPMAJ_LSB  = 21;
  localparam int unsigned OPMAJ_W    = 3;
  localparam int unsigned PRIM_LSB   = 16;
  localparam int unsigned CORE_LSB   = 12;
  localparam int unsigned OPMIN_LSB  = 5;
  localparam int unsigned OPMIN_W    = 3;
  localparam int unsigned SEC_LSB    = 0;

  localparam logic [IDX_W-1:0] CORE_PC = 4'd15;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_ID,
    SEL_CTYPE,
    SEL_CTRL,
    SEL_TBASE,
    SEL_DOMAIN,
    SEL_FSTAT,
    SEL_FADDR,
    SEL_CINV,
    SEL_TALL,
    SEL_TENT,
    SEL_ZERO
  } sel_e;

  typedef struct packed {
    logic             accept;
    logic             undef;
    sel_e             sel;
    logic [IDX_W-1:0] core_idx;
  } dec_t;
endpackage

// File: rtl/sysctl_cp_decode.sv
module sysctl_cp_decode
  import sysctl_cp_pkg::*;
(
  input  logic            valid_i,
  input  logic            write_i,
  input  logic [XLEN-1:0] instr_i,
  output dec_t            dec_o
);
  logic [OPMAJ_W-1:0] op_major;
  logic [OPMIN_W-1:0] op_minor;
  logic [IDX_W-1:0]   prim_reg, sec_reg, core_reg;
  logic               unused_bits;

  assign op_major = instr_i[OPMAJ_LSB +: OPMAJ_W];
  assign prim_reg = instr_i[PRIM_LSB +: IDX_W];
  assign core_reg = instr_i[CORE_LSB +: IDX_W];
  assign op_minor = instr_i[OPMIN_LSB +: OPMIN_W];
  assign sec_reg  = instr_i[SEC_LSB +: IDX_W];
  assign unused_bits = ^{instr_i[31:24], instr_i[20], instr_i[11:8], instr_i[4]};

  sel_e sel;
  logic undef;

  always_comb begin
    sel   = SEL_NONE;
    undef = 1'b0;
    unique case (prim_reg)
      4'd0: begin
        if (op_minor == 3'd0)      sel = SEL_ID;
        else if (op_minor == 3'd1) sel = SEL_CTYPE;
        else                       undef = 1'b1;
      end
      4'd1: sel = SEL_CTRL;
      4'd2: sel = SEL_TBASE;
      4'd3: sel = SEL_DOMAIN;
      4'd5: sel = SEL_FSTAT;
      4'd6: sel = SEL_FADDR;
      4'd7: begin
        if (!write_i)              sel = SEL_ZERO;
        else if (op_minor == 3'd0) sel = SEL_CINV;
      end
      4'd8: begin
        if (!write_i)              sel = SEL_ZERO;
        else if (op_minor == 3'd0) sel = SEL_TALL;
        else if (op_minor == 3'd1) sel = SEL_TENT;
      end
      default: undef = 1'b1;
    endcase
  end

  // writes ignore the secondary field, reads require it zero
  assign dec_o.accept   = valid_i && (op_major == '0) && (core_reg != CORE_PC)
                          && (write_i || (sec_reg == '0));
  assign dec_o.undef    = undef;
  assign dec_o.sel      = undef ? SEL_NONE : sel;
  assign dec_o.core_idx = core_reg;
endmodule

// File: rtl/sysctl_cp_regfile.sv
module sysctl_cp_regfile
  import sysctl_cp_pkg::*;
#(
  parameter logic [XLEN-1:0] ID_RESET    = 32'h1234_0A01,
  parameter logic [XLEN-1:0] CTYPE_RESET = 32'h0012_4050,
  parameter logic [XLEN-1:0] CTRL_RESET  = 32'h0000_0070
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  sel_e            sel_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic            fault_valid_i,
  input  logic [XLEN-1:0] fault_status_i,
  input  logic [XLEN-1:0] fault_addr_i,
  output logic [XLEN-1:0] rdata_o,
  output logic [XLEN-1:0] ctrl_o
);
  logic [XLEN-1:0] id_q, ctype_q, ctrl_q, tbase_q, domain_q, fstat_q, faddr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      id_q     <= ID_RESET;
      ctype_q  <= CTYPE_RESET;
      ctrl_q   <= CTRL_RESET;
      tbase_q  <= '0;
      domain_q <= '0;
      fstat_q  <= '0;
      faddr_q  <= '0;
    end else begin
      if (wr_en_i) begin
        case (sel_i)
          SEL_ID:     id_q     <= wdata_i;
          SEL_CTYPE:  ctype_q  <= wdata_i;
          SEL_CTRL:   ctrl_q   <= wdata_i;
          SEL_TBASE:  tbase_q  <= wdata_i;
          SEL_DOMAIN: domain_q <= wdata_i;
          SEL_FSTAT:  fstat_q  <= wdata_i;
          SEL_FADDR:  faddr_q  <= wdata_i;
          default: ;
        endcase
      end
      // fault path overrides a same-cycle write
      if (fault_valid_i) begin
        fstat_q <= fault_status_i;
        faddr_q <= fault_addr_i;
      end
    end
  end

  always_comb begin
    case (sel_i)
      SEL_ID:     rdata_o = id_q;
      SEL_CTYPE:  rdata_o = ctype_q;
      SEL_CTRL:   rdata_o = ctrl_q;
      SEL_TBASE:  rdata_o = tbase_q;
      SEL_DOMAIN: rdata_o = domain_q;
      SEL_FSTAT:  rdata_o = fstat_q;
      SEL_FADDR:  rdata_o = faddr_q;
      default:    rdata_o = '0;
    endcase
  end

  assign ctrl_o = ctrl_q;

  // R10
  fault_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_valid_i |=> (fstat_q == $past(fault_status_i)) && (faddr_q == $past(fault_addr_i)));
endmodule

// File: rtl/sysctl_cp_maint.sv
module sysctl_cp_maint
  import sysctl_cp_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            fire_i,
  input  sel_e            sel_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic            cache_inv_all_o,
  output logic            tlb_inv_all_o,
  output logic            tlb_inv_entry_o,
  output logic [XLEN-1:0] tlb_inv_addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cache_inv_all_o <= 1'b0;
      tlb_inv_all_o   <= 1'b0;
      tlb_inv_entry_o <= 1'b0;
      tlb_inv_addr_o  <= '0;
    end else begin
      cache_inv_all_o <= fire_i && (sel_i == SEL_CINV);
      tlb_inv_all_o   <= fire_i && (sel_i == SEL_TALL);
      tlb_inv_entry_o <= fire_i && (sel_i == SEL_TENT);
      if (fire_i && (sel_i == SEL_TENT)) tlb_inv_addr_o <= wdata_i;
    end
  end

  // R6
  inv_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cache_inv_all_o, tlb_inv_all_o, tlb_inv_entry_o}));
  // R7
  tlb_entry_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tlb_inv_entry_o |-> (tlb_inv_addr_o == $past(wdata_i)));
endmodule

// File: rtl/sysctl_cp_regs.sv
module sysctl_cp_regs
  import sysctl_cp_pkg::*;
#(
  parameter logic [31:0] ID_RESET    = 32'h1234_0A01,
  parameter logic [31:0] CTYPE_RESET = 32'h0012_4050
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        xfer_valid_i,
  input  logic        xfer_write_i,
  input  logic [31:0] instr_i,
  input  logic [31:0] core_wdata_i,
  output logic        rd_valid_o,
  output logic [3:0]  rd_dest_o,
  output logic [31:0] rd_data_o,
  output logic        undef_o,
  input  logic        fault_valid_i,
  input  logic [31:0] fault_status_i,
  input  logic [31:0] fault_addr_i,
  output logic        cache_inv_all_o,
  output logic        tlb_inv_all_o,
  output logic        tlb_inv_entry_o,
  output logic [31:0] tlb_inv_addr_o,
  output logic        mmu_en_o,
  output logic        align_chk_en_o,
  output logic        cache_en_o
);
  localparam logic [XLEN-1:0] CTRL_RESET = 32'h0000_0070;

  dec_t            dec;
  logic            wr_fire, rd_fire;
  logic [XLEN-1:0] rdata, ctrl;

  sysctl_cp_decode u_decode (
    .valid_i (xfer_valid_i),
    .write_i (xfer_write_i),
    .instr_i (instr_i),
    .dec_o   (dec)
  );

  assign wr_fire = dec.accept && xfer_write_i && !dec.undef;
  assign rd_fire = dec.accept && !xfer_write_i && !dec.undef;

  sysctl_cp_regfile #(
    .ID_RESET    (ID_RESET),
    .CTYPE_RESET (CTYPE_RESET),
    .CTRL_RESET  (CTRL_RESET)
  ) u_regfile (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .wr_en_i        (wr_fire),
    .sel_i          (dec.sel),
    .wdata_i        (core_wdata_i),
    .fault_valid_i  (fault_valid_i),
    .fault_status_i (fault_status_i),
    .fault_addr_i   (fault_addr_i),
    .rdata_o        (rdata),
    .ctrl_o         (ctrl)
  );

  sysctl_cp_maint u_maint (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .fire_i          (wr_fire),
    .sel_i           (dec.sel),
    .wdata_i         (core_wdata_i),
    .cache_inv_all_o (cache_inv_all_o),
    .tlb_inv_all_o   (tlb_inv_all_o),
    .tlb_inv_entry_o (tlb_inv_entry_o),
    .tlb_inv_addr_o  (tlb_inv_addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_dest_o  <= '0;
      rd_data_o  <= '0;
      undef_o    <= 1'b0;
    end else begin
      rd_valid_o <= rd_fire;
      undef_o    <= dec.accept && dec.undef;
      if (rd_fire) begin
        rd_dest_o <= dec.core_idx;
        rd_data_o <= rdata;
      end
    end
  end

  // R11
  assign mmu_en_o       = ctrl[0];
  assign align_chk_en_o = ctrl[1];
  assign cache_en_o     = ctrl[2];

  // R2
  read_sec_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_valid_i && !xfer_write_i && (instr_i[3:0] != 4'd0)) |=> !rd_valid_o && !undef_o);
  // R9
  undef_no_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    undef_o |-> $stable(ctrl) && !cache_inv_all_o && !tlb_inv_all_o && !tlb_inv_entry_o);
  // R1
  write_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_valid_i && xfer_write_i && ((instr_i[23:21] != 3'd0) || (instr_i[15:12] == 4'd15)))
      |=> $stable(ctrl) && !cache_inv_all_o && !tlb_inv_all_o && !tlb_inv_entry_o && !undef_o);
  // R3
  rd_origin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(xfer_valid_i && !xfer_write_i));
endmodule

// File: tb/sysctl_cp_regs_tb_top.sv
module sysctl_cp_regs_tb_top;
  localparam logic [31:0] ID_P    = 32'h1234_0A01;
  localparam logic [31:0] CTYPE_P = 32'h0012_4050;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xv = 1'b0, xw = 1'b0, fv = 1'b0;
  logic [31:0] ins = '0, wd = '0, fs = '0, fa = '0;
  logic rv, und, cinv, tall, tent, mmu, alg, cen;
  logic [3:0] dest;
  logic [31:0] rdat, taddr;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic g_rv, g_und, g_cinv, g_tall, g_tent;
  logic [3:0] g_dest;
  logic [31:0] g_data, g_taddr;

  always #2 clk = ~clk;

  sysctl_cp_regs #(.ID_RESET(ID_P), .CTYPE_RESET(CTYPE_P)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .xfer_valid_i(xv), .xfer_write_i(xw),
    .instr_i(ins), .core_wdata_i(wd), .rd_valid_o(rv), .rd_dest_o(dest),
    .rd_data_o(rdat), .undef_o(und), .fault_valid_i(fv), .fault_status_i(fs),
    .fault_addr_i(fa), .cache_inv_all_o(cinv), .tlb_inv_all_o(tall),
    .tlb_inv_entry_o(tent), .tlb_inv_addr_o(taddr), .mmu_en_o(mmu),
    .align_chk_en_o(alg), .cache_en_o(cen)
  );

  function automatic logic [31:0] mk(input logic [2:0] opj, input logic [3:0] prim,
                                     input logic [3:0] core, input logic [2:0] opn,
                                     input logic [3:0] sec);
    logic [31:0] w = 32'hEE00_0000;
    w[23:21] = opj; w[19:16] = prim; w[15:12] = core; w[7:5] = opn; w[3:0] = sec;
    return w;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic xfer(input bit w, input logic [31:0] i, input logic [31:0] d);
    @(negedge clk); xv = 1'b1; xw = w; ins = i; wd = d;
    @(negedge clk); xv = 1'b0;
    g_rv = rv; g_und = und; g_cinv = cinv; g_tall = tall; g_tent = tent;
    g_dest = dest; g_data = rdat; g_taddr = taddr;
  endtask

  task automatic rd_reg(input logic [3:0] prim, input logic [2:0] opn, input string req,
                        input logic [31:0] exp);
    xfer(1'b0, mk(3'd0, prim, 4'd3, opn, 4'd0), 32'h0);
    chk(g_rv && g_data == exp && g_dest == 4'd3, req, g_data, exp);
  endtask

  task automatic t_reset;
    chk(!mmu && !alg && !cen, "R5", {29'd0, cen, alg, mmu}, 32'h0);
    chk(!cinv && !tall && !tent && !rv && !und, "R5", {27'd0, cinv, tall, tent, rv, und}, 32'h0);
    rd_reg(4'd1, 3'd0, "R5", 32'h70);
    rd_reg(4'd2, 3'd0, "R5", 32'h0);
    rd_reg(4'd5, 3'd0, "R5", 32'h0);
    rd_reg(4'd0, 3'd0, "R4", ID_P);
    rd_reg(4'd0, 3'd1, "R4", CTYPE_P);
  endtask

  task automatic t_map;
    xfer(1'b1, mk(0, 4'd1, 4'd2, 0, 0), 32'h0000_0007);
    chk(mmu && alg && cen, "R11", {29'd0, cen, alg, mmu}, 32'h7);
    xfer(1'b1, mk(0, 4'd1, 4'd2, 0, 0), 32'h0000_0002);
    chk(!mmu && alg && !cen, "R11", {29'd0, cen, alg, mmu}, 32'h2);
    rd_reg(4'd1, 3'd0, "R3", 32'h2);
    xfer(1'b1, mk(0, 4'd2, 4'd0, 0, 0), 32'hA5A5_4000);
    xfer(1'b1, mk(0, 4'd3, 4'd1, 0, 0), 32'h5555_AAAA);
    xfer(1'b1, mk(0, 4'd5, 4'd4, 0, 0), 32'h0000_00F1);
    xfer(1'b1, mk(0, 4'd6, 4'd5, 0, 0), 32'hDEAD_0010);
    rd_reg(4'd2, 3'd0, "R3", 32'hA5A5_4000);
    rd_reg(4'd3, 3'd0, "R3", 32'h5555_AAAA);
    rd_reg(4'd5, 3'd0, "R3", 32'h0000_00F1);
    rd_reg(4'd6, 3'd0, "R3", 32'hDEAD_0010);
    xfer(1'b0, mk(0, 4'd2, 4'd9, 0, 0), 32'h0);
    chk(g_dest == 4'd9, "R3", {28'd0, g_dest}, 32'h9);
  endtask

  task automatic t_id;
    xfer(1'b1, mk(0, 4'd0, 4'd1, 3'd0, 0), 32'hCAFE_0001);
    xfer(1'b1, mk(0, 4'd0, 4'd1, 3'd1, 0), 32'hBEEF_0002);
    rd_reg(4'd0, 3'd0, "R4", 32'hCAFE_0001);
    rd_reg(4'd0, 3'd1, "R4", 32'hBEEF_0002);
  endtask

  task automatic t_ignore;
    xfer(1'b1, mk(3'd1, 4'd2, 4'd0, 0, 0), 32'h1111_1111);
    chk(!g_und && !g_cinv, "R1", {31'd0, g_und}, 32'h0);
    rd_reg(4'd2, 3'd0, "R1", 32'hA5A5_4000);
    xfer(1'b1, mk(3'd0, 4'd2, 4'd15, 0, 0), 32'h2222_2222);
    rd_reg(4'd2, 3'd0, "R1", 32'hA5A5_4000);
    xfer(1'b1, mk(3'd0, 4'd7, 4'd15, 0, 0), 32'h0);
    chk(!g_cinv, "R1", {31'd0, g_cinv}, 32'h0);
    xfer(1'b1, mk(3'd0, 4'd3, 4'd1, 0, 4'd6), 32'h0F0F_0F0F);
    rd_reg(4'd3, 3'd0, "R12", 32'h0F0F_0F0F);
    xfer(1'b0, mk(3'd0, 4'd3, 4'd1, 0, 4'd2), 32'h0);
    chk(!g_rv && !g_und, "R2", {31'd0, g_rv}, 32'h0);
    xfer(1'b0, mk(3'd0, 4'd3, 4'd15, 0, 0), 32'h0);
    chk(!g_rv && !g_und, "R2", {31'd0, g_rv}, 32'h0);
    xfer(1'b0, mk(3'd2, 4'd3, 4'd1, 0, 0), 32'h0);
    chk(!g_rv && !g_und, "R2", {31'd0, g_rv}, 32'h0);
  endtask

  task automatic t_maint;
    xfer(1'b1, mk(0, 4'd7, 4'd1, 3'd0, 0), 32'h0);
    chk(g_cinv && !g_tall && !g_tent, "R6", {29'd0, g_cinv, g_tall, g_tent}, 32'h4);
    @(negedge clk);
    chk(!cinv, "R6", {31'd0, cinv}, 32'h0);
    xfer(1'b1, mk(0, 4'd7, 4'd1, 3'd2, 0), 32'h0);
    chk(!g_cinv && !g_und, "R6", {31'd0, g_cinv}, 32'h0);
    xfer(1'b1, mk(0, 4'd8, 4'd1, 3'd0, 0), 32'h0);
    chk(g_tall && !g_tent && !g_cinv, "R7", {29'd0, g_cinv, g_tall, g_tent}, 32'h2);
    xfer(1'b1, mk(0, 4'd8, 4'd1, 3'd1, 0), 32'h8000_3000);
    chk(g_tent && !g_tall && g_taddr == 32'h8000_3000, "R7", g_taddr, 32'h8000_3000);
    @(negedge clk);
    chk(!tent, "R7", {31'd0, tent}, 32'h0);
    rd_reg(4'd7, 3'd0, "R8", 32'h0);
    rd_reg(4'd8, 3'd1, "R8", 32'h0);
  endtask

  task automatic t_undef;
    xfer(1'b1, mk(0, 4'd4, 4'd1, 0, 0), 32'hFFFF_FFFF);
    chk(g_und && !g_rv, "R9", {31'd0, g_und}, 32'h1);
    rd_reg(4'd1, 3'd0, "R9", 32'h2);
    xfer(1'b0, mk(0, 4'd12, 4'd1, 0, 0), 32'h0);
    chk(g_und && !g_rv, "R9", {31'd0, g_und}, 32'h1);
    xfer(1'b1, mk(0, 4'd0, 4'd1, 3'd3, 0), 32'h0);
    chk(g_und, "R9", {31'd0, g_und}, 32'h1);
    rd_reg(4'd0, 3'd0, "R9", 32'hCAFE_0001);
  endtask

  task automatic t_fault;
    @(negedge clk); fv = 1'b1; fs = 32'h0000_0025; fa = 32'h4000_1234;
    @(negedge clk); fv = 1'b0;
    rd_reg(4'd5, 3'd0, "R10", 32'h0000_0025);
    rd_reg(4'd6, 3'd0, "R10", 32'h4000_1234);
    @(negedge clk); fv = 1'b1; fs = 32'h0000_0007; fa = 32'h0000_0BAD;
    xv = 1'b1; xw = 1'b1; ins = mk(0, 4'd5, 4'd1, 0, 0); wd = 32'h9999_9999;
    @(negedge clk); fv = 1'b0; xv = 1'b0;
    rd_reg(4'd5, 3'd0, "R10", 32'h0000_0007);
    rd_reg(4'd6, 3'd0, "R10", 32'h0000_0BAD);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_map();
    t_id();
    t_ignore();
    t_maint();
    t_undef();
    t_fault();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule